// File: doc/BRIEF.md
# Half-Depth Multiplexer Lookup Table

This block computes an arbitrary Boolean function of `NUM_VARS` inputs with a multiplexer that has only half as many data inputs as the function has truth-table rows. All inputs except the lowest-numbered one form a binary select index. The highest-numbered input is the most significant select bit. The lowest input, `vars[0]`, is the data variable. It never reaches the select lines. Instead, each multiplexer data input is driven by one of four sources, chosen by a 2-bit code kept for that row: constant zero, constant one, the data variable, or the data variable inverted.

The row codes sit in registers and are written one row at a time through a write-enable port. After the codes are loaded, the output follows the inputs combinationally, with no clock involved. An active-low asynchronous reset sets every row to constant zero. Deriving the codes from a truth table is left to whatever loads the block. For row `k`, let the table entries at `{k,0}` and `{k,1}` be called `lo` and `hi`. The code is then zero when both are 0, one when both are 1, the data variable when lo=0 and hi=1, and its complement when lo=1 and hi=0.

Top module: `halfdepth_lut`

## Requirements
- R1: While `rstN` is low, and after it rises until the first write, every row code is 00, so `fOut` is 0 for every input pattern.
- R2: The select index is `vars[NUM_VARS-1:1]` read as an unsigned number, with `vars[NUM_VARS-1]` as its most significant bit. `vars[0]` is never a select bit.
- R3: A selected row holding code 00 drives `fOut` to 0, and one holding code 01 drives it to 1, whatever the value of `vars[0]`.
- R4: A selected row holding code 10 drives `fOut` to `vars[0]`, and one holding code 11 drives it to the inverse of `vars[0]`.
- R5: When `cfgWrEn` is high at a rising clock edge, row `cfgWrRow` takes the code `cfgWrCode`, which is visible from the next cycle on. All other rows keep their codes.
- R6: While `cfgWrEn` is low, no row code changes, whatever `cfgWrRow` and `cfgWrCode` carry.
- R7: `fOut` depends combinationally on `vars`: a change of `vars` shows at the output without a clock edge.
- R8: With the default of four variables, every 16-entry truth table (entry index `{vars[3],vars[2],vars[1],vars[0]}`) is reproduced at `fOut` once its eight derived row codes are loaded.
- R9: With three variables, loading codes 11, 11, 00, 01 into rows 0 to 3 gives the function that is 1 for input patterns 0, 2, 6 and 7 and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rstN | input | 1 | Asynchronous active-low reset; clears all row codes |
| cfgWrEn | input | 1 | Row-code write strobe |
| cfgWrRow | input | NUM_VARS-1 | Row to be written |
| cfgWrCode | input | 2 | Code written: 00 zero, 01 one, 10 data variable, 11 inverted data variable |
| vars | input | NUM_VARS | Function inputs; bit 0 is the data variable, the others form the select index |
| fOut | output | 1 | Function value |

## Verification
The bench builds two instances. The first uses the default four variables, which gives an 8-row table and a 16-pattern input space. That is small enough to sweep every input pattern after each load, for hand-picked truth tables and for random ones. The second uses three variables. It reaches the 4-row case, in which the mux tree has only two levels, and it carries the worked three-input function. Between them, the two instances cover both the full truth-table-to-code mapping and the bit ordering of the select index.

// File: rtl/hdlut_pkg.sv
package hdlut_pkg;

  // Source chosen for one multiplexer data input.
  typedef enum logic [1:0] {
    SRC_ZERO = 2'b00,
    SRC_ONE  = 2'b01,
    SRC_VAR  = 2'b10,
    SRC_NVAR = 2'b11
  } rowSrc_e;

  // Strobes from the control path into the datapath.
  typedef struct packed {
    logic    load;
    rowSrc_e code;
  } cfgStrobe_t;

  function automatic logic pickSource(rowSrc_e src, logic dataVar);
    logic res;
    unique case (src)
      SRC_ZERO: res = 1'b0;
      SRC_ONE:  res = 1'b1;
      SRC_VAR:  res = dataVar;
      default:  res = ~dataVar;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/hdlut_ctrl.sv
module hdlut_ctrl
  import hdlut_pkg::*;
#(
  parameter int NUM_VARS = 4
) (
  input  logic                cfgWrEn,
  input  logic [NUM_VARS-2:0] cfgWrRow,
  input  logic [1:0]          cfgWrCode,
  output cfgStrobe_t          strobe,
  output logic [(2**(NUM_VARS-1))-1:0] rowHit
);

  localparam int ROWS = 2 ** (NUM_VARS - 1);

  assign strobe.load = cfgWrEn;
  assign strobe.code = rowSrc_e'(cfgWrCode);

  // One-hot decode of the row address.
  for (genvar r = 0; r < ROWS; r++) begin : g_rowDec
    assign rowHit[r] = (cfgWrRow == (NUM_VARS - 1)'(r));
  end

endmodule

// File: rtl/hdlut_datapath.sv
module hdlut_datapath
  import hdlut_pkg::*;
#(
  parameter int NUM_VARS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfgStrobe_t          strobe,
  input  logic [(2**(NUM_VARS-1))-1:0] rowHit,
  input  logic [NUM_VARS-1:0] vars,
  output logic [(2**(NUM_VARS-1))-1:0][1:0] cfgRows,
  output logic                fOut
);

  localparam int SEL_W = NUM_VARS - 1;
  localparam int ROWS  = 2 ** SEL_W;

  logic [ROWS-1:0]  leafBit;
  logic [SEL_W-1:0] selBits;
  logic             dataVar;

  assign selBits = vars[NUM_VARS-1:1];
  assign dataVar = vars[0];

  // Row-code storage.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) cfgRows[r] <= SRC_ZERO;
    end else if (strobe.load) begin
      for (int r = 0; r < ROWS; r++) begin
        if (rowHit[r]) cfgRows[r] <= strobe.code;
      end
    end
  end

  // Per-row source selection.
  for (genvar r = 0; r < ROWS; r++) begin : g_leaf
    assign leafBit[r] = pickSource(rowSrc_e'(cfgRows[r]), dataVar);
  end

  // Binary mux tree, least significant select bit nearest the leaves.
  always_comb begin
    logic [ROWS-1:0] cur;
    cur = leafBit;
    for (int l = 0; l < SEL_W; l++) begin
      for (int j = 0; j < (ROWS >> (l + 1)); j++) begin
        cur[j] = selBits[l] ? cur[2*j+1] : cur[2*j];
      end
    end
    fOut = cur[0];
  end

endmodule

// File: rtl/halfdepth_lut.sv
module halfdepth_lut
  import hdlut_pkg::*;
#(
  parameter int NUM_VARS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [NUM_VARS-2:0] cfgWrRow,
  input  logic [1:0]          cfgWrCode,
  input  logic [NUM_VARS-1:0] vars,
  output logic                fOut
);

  localparam int ROWS = 2 ** (NUM_VARS - 1);

  cfgStrobe_t               strobe;
  logic [ROWS-1:0]          rowHit;
  logic [ROWS-1:0][1:0]     cfgRows;

  hdlut_ctrl #(.NUM_VARS(NUM_VARS)) u_ctrl (
    .cfgWrEn   (cfgWrEn),
    .cfgWrRow  (cfgWrRow),
    .cfgWrCode (cfgWrCode),
    .strobe    (strobe),
    .rowHit    (rowHit)
  );

  hdlut_datapath #(.NUM_VARS(NUM_VARS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rowHit  (rowHit),
    .vars    (vars),
    .cfgRows (cfgRows),
    .fOut    (fOut)
  );

endmodule

// File: rtl/halfdepth_lut_chk.sv
module halfdepth_lut_chk #(
  parameter int NUM_VARS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgWrEn,
  input logic [NUM_VARS-2:0] cfgWrRow,
  input logic [1:0]          cfgWrCode,
  input logic [NUM_VARS-1:0] vars,
  input logic [(2**(NUM_VARS-1))-1:0][1:0] cfgRows,
  input logic                fOut
);

  logic [1:0] selCode;
  assign selCode = cfgRows[vars[NUM_VARS-1:1]];

  // R3
  p_zero_row_r3: assert property (@(posedge clk) disable iff (!rstN)
    (selCode == 2'b00) |-> !fOut);
  // R3
  p_one_row_r3: assert property (@(posedge clk) disable iff (!rstN)
    (selCode == 2'b01) |-> fOut);
  // R4
  p_var_row_r4: assert property (@(posedge clk) disable iff (!rstN)
    (selCode == 2'b10) |-> (fOut == vars[0]));
  // R4
  p_nvar_row_r4: assert property (@(posedge clk) disable iff (!rstN)
    (selCode == 2'b11) |-> (fOut == !vars[0]));
  // R5
  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (cfgRows[$past(cfgWrRow)] == $past(cfgWrCode)));
  // R6
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(cfgRows));

endmodule

bind halfdepth_lut halfdepth_lut_chk #(.NUM_VARS(NUM_VARS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrEn   (cfgWrEn),
  .cfgWrRow  (cfgWrRow),
  .cfgWrCode (cfgWrCode),
  .vars      (vars),
  .cfgRows   (cfgRows),
  .fOut      (fOut)
);

// File: tb/halfdepth_lut_tb.sv
`timescale 1ns/1ps
module halfdepth_lut_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrRow = '0;
  logic [1:0] wrCode = '0;
  logic [3:0] vars = '0;
  logic       fOut;

  logic       wrEn3 = 1'b0;
  logic [1:0] wrRow3 = '0;
  logic [1:0] wrCode3 = '0;
  logic [2:0] vars3 = '0;
  logic       fOut3;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  halfdepth_lut #(.NUM_VARS(4)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(wrEn), .cfgWrRow(wrRow),
    .cfgWrCode(wrCode), .vars(vars), .fOut(fOut));

  halfdepth_lut #(.NUM_VARS(3)) u_dut3 (
    .clk(clk), .rstN(rstN), .cfgWrEn(wrEn3), .cfgWrRow(wrRow3),
    .cfgWrCode(wrCode3), .vars(vars3), .fOut(fOut3));

  // Truth tables, entry index {v3,v2,v1,v0}.
  localparam logic [15:0] TT_VEC [8] = '{
    16'h0000, 16'hFFFF, 16'hAAAA, 16'h5555,
    16'h6996, 16'hE880, 16'h1234, 16'hF00F
  };

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] codeFor(logic lo, logic hi);
    if (!lo && !hi) return 2'b00;
    if (lo && hi)   return 2'b01;
    if (!lo && hi)  return 2'b10;
    return 2'b11;
  endfunction

  task automatic writeRow(logic [2:0] row, logic [1:0] code);
    @(negedge clk);
    wrEn = 1'b1; wrRow = row; wrCode = code;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadTable(logic [15:0] tt);
    for (int r = 0; r < 8; r++)
      writeRow(3'(r), codeFor(tt[2*r], tt[2*r+1]));
  endtask

  task automatic sweep(string tag, logic [15:0] tt);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      vars = 4'(v);
      #1;
      check(tag, fOut, tt[v]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    sweep("R1 in reset", 16'h0000);
    rstN = 1'b1;
    sweep("R1 after reset", 16'h0000);

    // R2/R3/R5: single row write, ordering of select bits
    writeRow(3'd5, 2'b01);
    sweep("R2 R3 R5 row5 one", 16'h0C00);
    writeRow(3'd5, 2'b10);
    sweep("R4 R5 row5 var", 16'h0800);
    writeRow(3'd5, 2'b11);
    sweep("R4 R5 row5 nvar", 16'h0400);
    writeRow(3'd5, 2'b00);
    sweep("R3 R5 row5 zero", 16'h0000);

    // R8: table of vectors
    for (int i = 0; i < 8; i++) begin
      loadTable(TT_VEC[i]);
      sweep("R8 table", TT_VEC[i]);
    end

    // R8: random truth tables
    for (int i = 0; i < 20; i++) begin
      logic [15:0] tt;
      tt = 16'($urandom);
      loadTable(tt);
      sweep("R8 random", tt);
    end

    // R6: write enable low, busy address/data
    loadTable(16'h6996);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      wrRow = 3'($urandom); wrCode = 2'($urandom);
    end
    sweep("R6 hold", 16'h6996);

    // R7: output follows inputs without an edge
    @(negedge clk);
    vars = 4'd0; #1; check("R7 comb a", fOut, 1'b0);
    vars = 4'd1; #1; check("R7 comb b", fOut, 1'b1);
    vars = 4'd3; #1; check("R7 comb c", fOut, 1'b0);

    // R1: asynchronous reset mid-run
    loadTable(16'hFFFF);
    @(negedge clk);
    vars = 4'd9;
    #1 check("R1 before mid reset", fOut, 1'b1);
    #1 rstN = 1'b0;
    #1 check("R1 async clear", fOut, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    sweep("R1 after mid reset", 16'h0000);

    // R9: three-variable instance, codes 11,11,00,01
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      wrEn3 = 1'b1; wrRow3 = 2'(r);
      wrCode3 = (r < 2) ? 2'b11 : ((r == 2) ? 2'b00 : 2'b01);
      @(negedge clk);
      wrEn3 = 1'b0;
    end
    for (int v = 0; v < 8; v++) begin
      logic [7:0] exp3;
      exp3 = 8'hC5;
      @(negedge clk);
      vars3 = 3'(v);
      #1;
      check("R9 three-var", fOut3, exp3[v]);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule